// File: doc/BRIEF.md
# Term-Count Speculative Completion Timer

This block times a shift-add multiply under a four-phase request/acknowledge handshake. The delay before the acknowledge depends on how many coefficient terms the stored operand holds. The coefficient arrives already decoded as a zero-term flag and two enable bits. The block captures them when the request rises. It then chains a shift segment, an adder-1 segment and an adder-2 segment, but only as far as the terms require. A one-term product therefore acknowledges after the shift segment alone. A product with no terms acknowledges at once.

The same sequence raises the enables for the two add/subtract stages, so an unused adder never toggles. Each segment is a parameterised count of clock cycles. The adder-1 segment is meant to be shorter than the adder-2 segment. Releasing the request returns everything to zero. A release before the acknowledge abandons the request: no acknowledge is ever raised for it.

Top module: `spec_done_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, ack_o, add1_en_o and add2_en_o are 0.
- R2: All latencies are counted in rising edges after the edge that first samples req_i high. If zero_term_i is 1 at that edge, ack_o rises with latency 0 whatever the enable bits are, and neither adder enable is asserted.
- R3: When zero_term_i=0 and en1_i=0 (one term), ack_o rises at latency SHIFT_CYC and both adder enables stay 0. In this case en2_i has no effect.
- R4: When zero_term_i=0, en1_i=1 and en2_i=0 (two terms), add1_en_o rises at latency SHIFT_CYC and ack_o rises at SHIFT_CYC+ADD1_CYC. add2_en_o stays 0.
- R5: With all three terms (en1_i=en2_i=1), add1_en_o rises at SHIFT_CYC, add2_en_o at SHIFT_CYC+ADD1_CYC and ack_o at SHIFT_CYC+ADD1_CYC+ADD2_CYC. add2_en_o is never high while add1_en_o is low.
- R6: Once raised, ack_o and the adder enables stay high for as long as req_i stays high.
- R7: After req_i is sampled low, ack_o and add1_en_o are 0 in the next cycle. add2_en_o is ANDed with req_i and drops in the same cycle req_i drops.
- R8: If req_i falls before ack_o rises, ack_o is never raised for that request, and all enables and the pending count clear in the next cycle. A later request then runs its full sequence.
- R9: zero_term_i, en1_i and en2_i are sampled only at the rising edge of req_i. Changes to them during the sequence have no effect.
- R10: A new request is started only by a rising edge of req_i that comes after req_i was sampled low. One low cycle between requests is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Four-phase request |
| zero_term_i | input | 1 | Coefficient has no terms |
| en1_i | input | 1 | Second term present |
| en2_i | input | 1 | Third term present |
| add1_en_o | output | 1 | Enable for add/subtract stage 1 |
| add2_en_o | output | 1 | Enable for add/subtract stage 2 |
| ack_o | output | 1 | Four-phase acknowledge |

## Verification
The bench releases the request exactly one cycle before each acknowledge would appear, and also inside each segment. A design that let a pending count finish after the release would then raise a stray acknowledge. It drives the zero flag together with set enables, and en2 without en1. A wrong priority would enable adders or lengthen the delay. It flips the term inputs right after the request edge, which a design that failed to hold them would follow into a different delay. It also sends requests back to back with a single low cycle between them, which exposes an edge detector or return-to-zero path that loses or merges requests.

// File: rtl/spec_done_timer_pkg.sv
`timescale 1ns/1ps
package spec_done_timer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SHIFT = 3'd1,
        PH_ADD1  = 3'd2,
        PH_ADD2  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic zero;
        logic en1;
        logic en2;
    } term_cfg_t;

    // Number of terms implied by a captured configuration (0..3).
    function automatic logic [1:0] term_count(input term_cfg_t c);
        if (c.zero)
            return 2'd0;
        else if (!c.en1)
            return 2'd1;
        else if (!c.en2)
            return 2'd2;
        else
            return 2'd3;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdt_req_edge.sv
`timescale 1ns/1ps
module sdt_req_edge (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic rise_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b1;   // a request held through reset is not a fresh edge
        else
            req_q <= req_i;
    end

    assign rise_o = req_i & ~req_q;
endmodule

// File: rtl/sdt_cfg_hold.sv
`timescale 1ns/1ps
module sdt_cfg_hold
    import spec_done_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture_i,
    input  term_cfg_t live_i,
    output term_cfg_t cfg_o
);
    term_cfg_t held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (capture_i)
            held_q <= live_i;
    end

    // On the capture cycle the live value is used directly.
    assign cfg_o = capture_i ? live_i : held_q;
endmodule

// File: rtl/sdt_seg_count.sv
`timescale 1ns/1ps
module sdt_seg_count #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdt_phase_ctrl.sv
`timescale 1ns/1ps
module sdt_phase_ctrl
    import spec_done_timer_pkg::*;
#(
    parameter int W         = 3,
    parameter int SHIFT_CYC = 2,
    parameter int ADD1_CYC  = 3,
    parameter int ADD2_CYC  = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         req_i,
    input  term_cfg_t    cfg_i,
    input  logic         seg_zero_i,
    output logic         load_o,
    output logic [W-1:0] load_val_o,
    output logic         clear_o,
    output logic         add1_q_o,
    output logic         add2_q_o,
    output logic         ack_o
);
    localparam logic [W-1:0] SHIFT_LD = W'(SHIFT_CYC - 1);
    localparam logic [W-1:0] ADD1_LD  = W'(ADD1_CYC - 1);
    localparam logic [W-1:0] ADD2_LD  = W'(ADD2_CYC - 1);

    phase_e     phase_q, phase_d;
    logic [1:0] terms;
    logic       add1_d, add2_d;

    assign terms = term_count(cfg_i);

    always_comb begin
        phase_d    = phase_q;
        load_o     = 1'b0;
        load_val_o = '0;
        clear_o    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    if (terms == 2'd0) begin
                        phase_d = PH_DONE;
                    end else begin
                        phase_d    = PH_SHIFT;
                        load_o     = 1'b1;
                        load_val_o = SHIFT_LD;
                    end
                end
            end
            PH_SHIFT: begin
                if (!req_i) begin
                    phase_d = PH_IDLE;
                    clear_o = 1'b1;
                end else if (seg_zero_i) begin
                    if (terms >= 2'd2) begin
                        phase_d    = PH_ADD1;
                        load_o     = 1'b1;
                        load_val_o = ADD1_LD;
                    end else begin
                        phase_d = PH_DONE;
                    end
                end
            end
            PH_ADD1: begin
                if (!req_i) begin
                    phase_d = PH_IDLE;
                    clear_o = 1'b1;
                end else if (seg_zero_i) begin
                    if (terms == 2'd3) begin
                        phase_d    = PH_ADD2;
                        load_o     = 1'b1;
                        load_val_o = ADD2_LD;
                    end else begin
                        phase_d = PH_DONE;
                    end
                end
            end
            PH_ADD2: begin
                if (!req_i) begin
                    phase_d = PH_IDLE;
                    clear_o = 1'b1;
                end else if (seg_zero_i) begin
                    phase_d = PH_DONE;
                end
            end
            PH_DONE: begin
                if (!req_i)
                    phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
                clear_o = 1'b1;
            end
        endcase
    end

    // Stage enables stay up from their segment until the return to zero.
    always_comb begin
        add1_d = (phase_d == PH_ADD1) || (phase_d == PH_ADD2) ||
                 ((phase_d == PH_DONE) && (terms >= 2'd2));
        add2_d = (phase_d == PH_ADD2) ||
                 ((phase_d == PH_DONE) && (terms == 2'd3));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            add1_q_o <= 1'b0;
            add2_q_o <= 1'b0;
            ack_o    <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            add1_q_o <= add1_d;
            add2_q_o <= add2_d;
            ack_o    <= (phase_d == PH_DONE);
        end
    end
endmodule

// File: rtl/spec_done_timer.sv
`timescale 1ns/1ps
module spec_done_timer
    import spec_done_timer_pkg::*;
#(
    parameter int SHIFT_CYC      = 2,
    parameter int ADD1_CYC       = 3,
    parameter int ADD2_CYC       = 4,
    parameter bit REQ_GATES_ADD2 = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic zero_term_i,
    input  logic en1_i,
    input  logic en2_i,
    output logic add1_en_o,
    output logic add2_en_o,
    output logic ack_o
);
    localparam int MAX_SEG = max3(SHIFT_CYC, ADD1_CYC, ADD2_CYC);
    localparam int CNT_W   = (MAX_SEG < 2) ? 1 : $clog2(MAX_SEG);

    logic             req_rise;
    term_cfg_t        live_cfg, cfg;
    logic             seg_load, seg_clear, seg_zero;
    logic [CNT_W-1:0] seg_val;
    logic             add1_q, add2_q;

    assign live_cfg = '{zero: zero_term_i, en1: en1_i, en2: en2_i};

    sdt_req_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .rise_o (req_rise)
    );

    sdt_cfg_hold u_cfg (
        .clk       (clk),
        .rst       (rst),
        .capture_i (req_rise),
        .live_i    (live_cfg),
        .cfg_o     (cfg)
    );

    sdt_seg_count #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (seg_clear),
        .load_i     (seg_load),
        .load_val_i (seg_val),
        .zero_o     (seg_zero)
    );

    sdt_phase_ctrl #(
        .W         (CNT_W),
        .SHIFT_CYC (SHIFT_CYC),
        .ADD1_CYC  (ADD1_CYC),
        .ADD2_CYC  (ADD2_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (req_rise),
        .req_i      (req_i),
        .cfg_i      (cfg),
        .seg_zero_i (seg_zero),
        .load_o     (seg_load),
        .load_val_o (seg_val),
        .clear_o    (seg_clear),
        .add1_q_o   (add1_q),
        .add2_q_o   (add2_q),
        .ack_o      (ack_o)
    );

    assign add1_en_o = add1_q;

    generate
        if (REQ_GATES_ADD2) begin : g_add2_gated
            assign add2_en_o = add2_q & req_i;
        end else begin : g_add2_plain
            assign add2_en_o = add2_q;
        end
    endgenerate
endmodule

// File: rtl/sdt_checker.sv
`timescale 1ns/1ps
module sdt_checker #(
    parameter bit REQ_GATES_ADD2 = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic add1_en_o,
    input logic add2_en_o,
    input logic ack_o
);
    // R7: release clears ack and adder-1 enable one cycle later
    a_r7_ack_release: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !ack_o);
    a_r7_add1_release: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !add1_en_o);

    generate
        if (REQ_GATES_ADD2) begin : g_gate_chk
            // R7: adder-2 enable never outlives the request
            a_r7_add2_gate: assert property (@(posedge clk) disable iff (rst)
                !req_i |-> !add2_en_o);
        end
    endgenerate

    // R5: adder 2 only runs with adder 1 enabled
    a_r5_add2_needs_add1: assert property (@(posedge clk) disable iff (rst)
        add2_en_o |-> add1_en_o);

    // R5: adder 2 is enabled after adder 1
    a_r5_add2_after_add1: assert property (@(posedge clk) disable iff (rst)
        $rose(add2_en_o) |-> $past(add1_en_o));

    // R6: outputs hold while the request is held
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (ack_o && req_i) |=> ack_o);
    a_r6_add1_holds: assert property (@(posedge clk) disable iff (rst)
        (add1_en_o && req_i) |=> add1_en_o);

    // R4: adder 1 is enabled before the acknowledge
    a_r4_add1_before_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(add1_en_o) |-> !ack_o);

    // R8: an acknowledge only follows a request sampled high
    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(req_i));
endmodule

bind spec_done_timer sdt_checker #(.REQ_GATES_ADD2(REQ_GATES_ADD2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .add1_en_o (add1_en_o),
    .add2_en_o (add2_en_o),
    .ack_o     (ack_o)
);

// File: tb/spec_done_timer_bench.sv
`timescale 1ns/1ps
module spec_done_timer_bench;
    localparam int S  = 2;
    localparam int A1 = 3;
    localparam int A2 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, zt = 1'b0, e1 = 1'b0, e2 = 1'b0;
    logic add1_en, add2_en, ack;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    ack;
        int    a1;
        int    a2;
        string tag;
    } exp_t;
    exp_t sb[$];

    spec_done_timer #(.SHIFT_CYC(S), .ADD1_CYC(A1), .ADD2_CYC(A2)) u_spec_done_timer (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .zero_term_i (zt),
        .en1_i       (e1),
        .en2_i       (e2),
        .add1_en_o   (add1_en),
        .add2_en_o   (add2_en),
        .ack_o       (ack)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Driver: raises a request held for 'hold' sampling edges and queues what must happen.
    task automatic do_req(input string rq, input bit z, input bit n1, input bit n2,
                          input int hold, input bit scramble);
        exp_t x;
        int   terms, lat;
        terms = z ? 0 : (!n1 ? 1 : (!n2 ? 2 : 3));
        lat   = (terms == 0) ? 0 : (terms == 1) ? S : (terms == 2) ? S + A1 : S + A1 + A2;
        x.ack = (lat <= hold - 1) ? lat : -1;
        x.a1  = (terms >= 2 && S <= hold - 1) ? S : -1;
        x.a2  = (terms == 3 && S + A1 <= hold - 2) ? S + A1 : -1;
        x.tag = rq;
        sb.push_back(x);
        @(posedge clk); #1;
        zt = z; e1 = n1; e2 = n2; req = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            if (scramble && i == 0) begin
                zt = ~z; e1 = ~n1; e2 = ~n2;
            end
        end
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({rq, " R7 ack low after release"}, int'(ack), 0);
        chk({rq, " R7 add1 low after release"}, int'(add1_en), 0);
        chk({rq, " R7 add2 low after release"}, int'(add2_en), 0);
    endtask

    // Monitor: measures latencies of each request and compares with the queue.
    bit act_m = 1'b0;
    int n = 0, g_ack = -1, g_a1 = -1, g_a2 = -1;
    bit dropped = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (act_m) begin
                n++;
                if (ack && g_ack < 0) g_ack = n - 1;
                if (!ack && g_ack >= 0) dropped = 1'b1;
                if (add1_en && g_a1 < 0) g_a1 = n - 1;
                if (!add1_en && g_a1 >= 0) dropped = 1'b1;
                if (req) begin
                    if (add2_en && g_a2 < 0) g_a2 = n - 1;
                    if (!add2_en && g_a2 >= 0) dropped = 1'b1;
                end else begin
                    exp_t x;
                    if (sb.size() == 0) begin
                        chk("R10 scoreboard underflow", 1, 0);
                    end else begin
                        x = sb.pop_front();
                        chk({x.tag, " ack latency"}, g_ack, x.ack);
                        chk({x.tag, " add1 latency"}, g_a1, x.a1);
                        chk({x.tag, " add2 latency"}, g_a2, x.a2);
                        chk({x.tag, " R6 outputs held"}, int'(dropped), 0);
                        chk({x.tag, " R7 add2 drops with req"}, int'(add2_en), 0);
                    end
                    act_m = 1'b0;
                end
            end
            if (req && !act_m) begin
                act_m = 1'b1; n = 0; g_ack = -1; g_a1 = -1; g_a2 = -1; dropped = 1'b0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ack in reset", int'(ack), 0);
        chk("R1 add1 in reset", int'(add1_en), 0);
        chk("R1 add2 in reset", int'(add2_en), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk("R1 ack after reset", int'(ack), 0);
        chk("R1 add1 after reset", int'(add1_en), 0);

        do_req("R2 zero term",             1, 0, 0, 3, 0);
        do_req("R2 zero overrides enables", 1, 1, 1, 3, 0);
        do_req("R3 one term",              0, 0, 0, 5, 0);
        do_req("R3 en2 ignored",           0, 0, 1, 5, 0);
        do_req("R4 two terms",             0, 1, 0, 8, 0);
        do_req("R5 three terms",           0, 1, 1, 12, 0);
        do_req("R6 long hold",             0, 1, 1, 20, 0);
        do_req("R8 abort in adder1",       0, 1, 1, 4, 0);
        do_req("R8 abort one before ack",  0, 0, 0, 2, 0);
        do_req("R8 abort just before ack", 0, 1, 1, 9, 0);
        do_req("R8 full after abort",      0, 1, 1, 12, 0);
        do_req("R9 held one term",         0, 0, 0, 6, 1);
        do_req("R9 held three terms",      0, 1, 1, 12, 1);
        do_req("R10 back to back a",       0, 1, 0, 6, 0);
        do_req("R10 back to back b",       1, 0, 0, 1, 0);
        do_req("R10 back to back c",       0, 0, 0, 3, 0);

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule